// File: doc/BRIEF.md
# Prescaled Timer with Write-One-to-Clear Status Flags

This block keeps a 16-bit free-running count that advances once per prescaler period. The prescaler period is 1, 4, 8 or 16 bus-clock cycles, picked by a 2-bit divide select. After reset the divide select accepts one write, and only during a short window. After that write, or once the window has closed, the select is frozen. The exception is while the special-mode input is held high: then the select can be rewritten at any time.

Three event sources set sticky status flags:
- the count wrapping from all ones to zero;
- a rising edge on the real-time tap input;
- an 8-bit event accumulator rolling over.

Software clears a flag by writing a one to its bit. A mask register with the same bit layout decides which set flags drive the single interrupt output.

Registers are reached through a simple single-cycle bus. A write happens on the clock edge where the write strobe is high. Read data follows the address combinationally.

Address map (3-bit address):

| Address | Register | Contents |
|---|---|---|
| 0 | count, upper byte | read only |
| 1 | count, lower byte | read only |
| 2 | divide select | bits [1:0] |
| 3 | interrupt mask | |
| 4 | status flags | |
| 5 | event accumulator | |
| 6, 7 | none | read as zero |

Top module: `prescaled_timer`

## Requirements
- R1: The divide select lives in bits [1:0] of address 2. The count advances once every 1, 4, 8 or 16 clocks for select values 0, 1, 2 and 3.
- R2: The count reads as upper byte at address 0 and lower byte at address 1. It is zero in reset and holds its value between prescaler terminal counts.
- R3: Outside special mode, the first accepted write to the divide select freezes it. Later writes leave it unchanged.
- R4: Outside special mode, a divide-select write is ignored once 64 clocks have passed since reset.
- R5: While the special-mode input is high, every write to the divide select takes effect.
- R6: Flag bit 7 of address 4 sets on the clock where the count steps from 0xFFFF to 0x0000.
- R7: Flag bit 6 sets on each rising edge of the tap input. A tap held high does not set it again.
- R8: Bit 5 sets when the 8-bit accumulator at address 5 wraps from 0xFF to 0x00. The accumulator counts clocks with the event input high.
- R9: Writing address 4 clears exactly the flags whose written bit is one. Flags written with zero keep their value.
- R10: When a flag's set event and a clearing write for that flag fall on the same clock, the flag ends set.
- R11: The interrupt output is high exactly when some flag is set with its bit also set in the mask at address 3. The mask implements bits 7 to 5 only.
- R12: Reset clears all flags, masks, the divide select and the accumulator. Bits 4 to 0 of the flag and mask registers always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_i | input | 1 | Special mode: divide select always writable |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data (combinational) |
| rt_tap_i | input | 1 | Real-time tap, rising edge sets flag bit 6 |
| pa_event_i | input | 1 | Accumulator event, counted each clock it is high |
| irq_o | output | 1 | Interrupt request |

## Verification
The count is measured over windows that are whole multiples of each divisor. This makes the expected advance independent of prescaler phase, and it separates a wrong divide decode from an off-by-one terminal count.

The divide-select protection is probed three ways:
- a second write inside the window;
- a first write after the window has closed;
- repeated writes under special mode.

Together these separate the write-once lock from the timed lock.

The flag tests cover several cases that separate sticky-set, clear and masking faults from one another:
- a tap held high;
- a write of zero;
- a write that targets a neighbouring bit;
- a set that coincides with its own clear;
- masks that do and do not match the pending flags.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int DATA_W  = 8;
   localparam int SEL_W   = 2;
   localparam int PRE_W   = 4;

   localparam int ADR_CNT_HI = 0;
   localparam int ADR_CNT_LO = 1;
   localparam int ADR_DIVSEL = 2;
   localparam int ADR_MASK   = 3;
   localparam int ADR_FLAGS  = 4;
   localparam int ADR_ACC    = 5;

   localparam int BIT_WRAP = 7;
   localparam int BIT_TAP  = 6;
   localparam int BIT_ACC  = 5;

   localparam logic [DATA_W-1:0] FLAG_IMPL =
      DATA_W'((1 << BIT_WRAP) | (1 << BIT_TAP) | (1 << BIT_ACC));

   // terminal count of the prescaler for a divide select: 0, 3, 7, 15
   function automatic logic [PRE_W-1:0] div_terminal(input logic [SEL_W-1:0] sel);
      logic [PRE_W:0] span;
      if (sel == '0) return '0;
      span = (PRE_W+1)'(1) << (sel + 1);
      return PRE_W'(span - 1'b1);
   endfunction

endpackage

// File: rtl/tmr_sel_lock.sv
module tmr_sel_lock
   import tmr_pkg::*;
#(
   parameter int LOCK_CYC = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             special_i,
   input  logic             wr_i,
   input  logic [SEL_W-1:0] wdata_i,
   output logic [SEL_W-1:0] sel_o,
   output logic             locked_o
);

   localparam int WIN_W = $clog2(LOCK_CYC + 1);

   if (LOCK_CYC < 1) begin : g_bad_lock
      $error("tmr_sel_lock: LOCK_CYC must be at least 1");
   end

   logic [WIN_W-1:0] win_q;
   logic             written_q;
   logic [SEL_W-1:0] sel_q;
   logic             win_open;
   logic             accept;

   assign win_open = (win_q < WIN_W'(LOCK_CYC));
   assign locked_o = written_q | ~win_open;
   assign accept   = wr_i & (special_i | ~locked_o);
   assign sel_o    = sel_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q     <= '0;
         written_q <= 1'b0;
         sel_q     <= '0;
      end else begin
         if (win_open) win_q <= win_q + 1'b1;
         if (accept) begin
            sel_q     <= wdata_i;
            written_q <= 1'b1;
         end
      end
   end

   // R3 / R4: once frozen, normal-mode writes do nothing
   p_locked_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (locked_o && !special_i) |=> $stable(sel_q));

   // R5: special mode always takes the written value
   p_special_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (special_i && wr_i) |=> (sel_q == $past(wdata_i)));

endmodule

// File: rtl/tmr_prescale_cnt.sv
module tmr_prescale_cnt
   import tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] sel_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] term;
   logic             tick;
   logic [CNT_W-1:0] cnt_q;

   assign term   = div_terminal(sel_i);
   assign tick   = (pre_q >= term);
   assign cnt_o  = cnt_q;
   assign wrap_o = tick & (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else begin
         pre_q <= tick ? '0 : pre_q + 1'b1;
         if (tick) cnt_q <= cnt_q + 1'b1;
      end
   end

   // R1: undivided select steps the count every clock
   p_div1_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_i == '0) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   // R2: between terminal counts the count holds
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt_q));

   // R6: a wrap event lands the count on zero
   p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (cnt_q == '0));

endmodule

// File: rtl/tmr_evt.sv
module tmr_evt #(
   parameter int ACC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tap_i,
   input  logic             ev_i,
   output logic             tap_rise_o,
   output logic [ACC_W-1:0] acc_o,
   output logic             roll_o
);

   logic             tap_q;
   logic [ACC_W-1:0] acc_q;

   assign tap_rise_o = tap_i & ~tap_q;
   assign roll_o     = ev_i & (&acc_q);
   assign acc_o      = acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tap_q <= 1'b0;
         acc_q <= '0;
      end else begin
         tap_q <= tap_i;
         if (ev_i) acc_q <= acc_q + 1'b1;
      end
   end

   // R8: rollover leaves the accumulator at zero
   p_acc_roll_r8: assert property (@(posedge clk) disable iff (!rst_n)
      roll_o |=> (acc_q == '0));

   // R7: a held tap yields no further rise
   p_tap_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_i && $stable(tap_i)) |=> (tap_i ? !tap_rise_o : 1'b1));

endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
   parameter int              DW   = 8,
   parameter logic [DW-1:0]   IMPL = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] set_i,
   input  logic          clr_wr_i,
   input  logic [DW-1:0] clr_data_i,
   input  logic          mask_wr_i,
   input  logic [DW-1:0] mask_data_i,
   output logic [DW-1:0] flags_o,
   output logic [DW-1:0] mask_o,
   output logic          irq_o
);

   for (genvar b = 0; b < DW; b++) begin : g_bit
      if (IMPL[b]) begin : g_on
         logic f_q;
         logic m_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               f_q <= 1'b0;
               m_q <= 1'b0;
            end else begin
               f_q <= set_i[b] | (f_q & ~(clr_wr_i & clr_data_i[b]));
               if (mask_wr_i) m_q <= mask_data_i[b];
            end
         end
         assign flags_o[b] = f_q;
         assign mask_o[b]  = m_q;

         // R10: a set event wins over a same-cycle clear
         p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> f_q);

         // R9: without a one written to this bit the flag stays set
         p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (f_q && !(clr_wr_i && clr_data_i[b])) |=> f_q);
      end else begin : g_off
         assign flags_o[b] = 1'b0;
         assign mask_o[b]  = 1'b0;
      end
   end

   assign irq_o = |(flags_o & mask_o);

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
   import tmr_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int ACC_W    = 8,
   parameter int LOCK_CYC = 64,
   parameter int ADDR_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              special_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [7:0]        bus_wdata_i,
   output logic [7:0]        bus_rdata_o,
   input  logic              rt_tap_i,
   input  logic              pa_event_i,
   output logic              irq_o
);

   if (CNT_W < 9 || CNT_W > 16) begin : g_bad_cnt
      $error("prescaled_timer: CNT_W must lie in 9..16");
   end
   if (ACC_W < 1 || ACC_W > 8) begin : g_bad_acc
      $error("prescaled_timer: ACC_W must lie in 1..8");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("prescaled_timer: ADDR_W must be at least 3");
   end

   logic             wr_sel, wr_mask, wr_flags;
   logic [SEL_W-1:0] sel;
   logic             locked;
   logic [CNT_W-1:0] cnt;
   logic             wrap;
   logic             tap_rise;
   logic [ACC_W-1:0] acc;
   logic             roll;
   logic [7:0]       set_vec;
   logic [7:0]       flags;
   logic [7:0]       mask;

   assign wr_sel   = bus_we_i && (bus_addr_i == ADDR_W'(ADR_DIVSEL));
   assign wr_mask  = bus_we_i && (bus_addr_i == ADDR_W'(ADR_MASK));
   assign wr_flags = bus_we_i && (bus_addr_i == ADDR_W'(ADR_FLAGS));

   tmr_sel_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
      .clk       (clk),
      .rst_n     (rst_n),
      .special_i (special_i),
      .wr_i      (wr_sel),
      .wdata_i   (bus_wdata_i[SEL_W-1:0]),
      .sel_o     (sel),
      .locked_o  (locked)
   );

   tmr_prescale_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (sel),
      .cnt_o  (cnt),
      .wrap_o (wrap)
   );

   tmr_evt #(.ACC_W(ACC_W)) u_evt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tap_i      (rt_tap_i),
      .ev_i       (pa_event_i),
      .tap_rise_o (tap_rise),
      .acc_o      (acc),
      .roll_o     (roll)
   );

   always_comb begin
      set_vec           = '0;
      set_vec[BIT_WRAP] = wrap;
      set_vec[BIT_TAP]  = tap_rise;
      set_vec[BIT_ACC]  = roll;
   end

   tmr_flags #(.DW(8), .IMPL(FLAG_IMPL)) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (set_vec),
      .clr_wr_i    (wr_flags),
      .clr_data_i  (bus_wdata_i),
      .mask_wr_i   (wr_mask),
      .mask_data_i (bus_wdata_i),
      .flags_o     (flags),
      .mask_o      (mask),
      .irq_o       (irq_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      case (int'(bus_addr_i))
         ADR_CNT_HI: bus_rdata_o = 8'(cnt >> 8);
         ADR_CNT_LO: bus_rdata_o = cnt[7:0];
         ADR_DIVSEL: bus_rdata_o = 8'(sel);
         ADR_MASK:   bus_rdata_o = mask;
         ADR_FLAGS:  bus_rdata_o = flags;
         ADR_ACC:    bus_rdata_o = 8'(acc);
         default:    bus_rdata_o = '0;
      endcase
   end

   // R12: unimplemented flag bits always read zero
   p_unused_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_i == ADDR_W'(ADR_FLAGS)) |-> (bus_rdata_o[4:0] == 5'd0));

   // R11: with nothing masked in, no interrupt
   p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq_o);

   // R3: a locked select ignores normal-mode writes (seen at the bus)
   p_sel_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !special_i) |=> $stable(sel));

endmodule

// File: tb/tb_prescaled_timer.sv
module tb_prescaled_timer;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       special_i = 1'b0;
   logic       bus_we_i = 1'b0;
   logic [2:0] bus_addr_i = '0;
   logic [7:0] bus_wdata_i = '0;
   logic [7:0] bus_rdata_o;
   logic       rt_tap_i = 1'b0;
   logic       pa_event_i = 1'b0;
   logic       irq_o;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   prescaled_timer dut (
      .clk(clk), .rst_n(rst_n), .special_i(special_i),
      .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
      .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
      .rt_tap_i(rt_tap_i), .pa_event_i(pa_event_i), .irq_o(irq_o)
   );

   // sel[17:16], window[15:8], expected advance[7:0]
   localparam logic [17:0] VEC [0:6] = '{
      {2'd0, 8'd32, 8'd32},
      {2'd1, 8'd32, 8'd8},
      {2'd2, 8'd32, 8'd4},
      {2'd3, 8'd64, 8'd4},
      {2'd1, 8'd12, 8'd3},
      {2'd0, 8'd5,  8'd5},
      {2'd3, 8'd48, 8'd3}
   };

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic rd8(input logic [2:0] a, output logic [7:0] d);
      bus_addr_i = a;
      #1 d = bus_rdata_o;
   endtask

   task automatic rd16(output logic [15:0] v);
      logic [7:0] h, l;
      rd8(3'd0, h);
      rd8(3'd1, l);
      v = {h, l};
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
      @(negedge clk);
      bus_we_i = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [7:0]  d;
      logic [15:0] c0, c1;
      int          guard;

      // reset state, R12 / R2
      repeat (2) @(negedge clk);
      rd16(c0);        chk("R2 count in reset", c0, 16'h0);
      rd8(3'd4, d);    chk("R12 flags in reset", {8'h0, d}, 16'h0);
      rd8(3'd3, d);    chk("R12 mask in reset", {8'h0, d}, 16'h0);
      rd8(3'd2, d);    chk("R12 select in reset", {8'h0, d}, 16'h0);
      rd8(3'd5, d);    chk("R12 accumulator in reset", {8'h0, d}, 16'h0);
      chk("R12 irq in reset", {15'h0, irq_o}, 16'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R3: first write accepted, second frozen
      wr(3'd2, 8'd2);
      rd8(3'd2, d);    chk("R3 first select write", {8'h0, d}, 16'h2);
      wr(3'd2, 8'd1);
      rd8(3'd2, d);    chk("R3 second select write ignored", {8'h0, d}, 16'h2);

      // R4: window expiry
      do_reset();
      repeat (70) @(negedge clk);
      wr(3'd2, 8'd3);
      rd8(3'd2, d);    chk("R4 late select write ignored", {8'h0, d}, 16'h0);

      // R5: special mode
      special_i = 1'b1;
      wr(3'd2, 8'd3);
      rd8(3'd2, d);    chk("R5 special write", {8'h0, d}, 16'h3);
      wr(3'd2, 8'd1);
      rd8(3'd2, d);    chk("R5 special rewrite", {8'h0, d}, 16'h1);

      // R1 / R2: divide table
      foreach (VEC[i]) begin
         wr(3'd2, {6'd0, VEC[i][17:16]});
         repeat (20) @(negedge clk);
         rd16(c0);
         repeat (int'(VEC[i][15:8])) @(negedge clk);
         rd16(c1);
         chk("R1 count advance per window", c1 - c0, {8'h0, VEC[i][7:0]});
      end
      special_i = 1'b0;

      // R7: tap edge
      wr(3'd4, 8'hFF);
      rt_tap_i = 1'b1;
      @(negedge clk);
      rd8(3'd4, d);    chk("R7 tap rise sets bit 6", {8'h0, d}, 16'h40);
      repeat (2) @(negedge clk);
      wr(3'd4, 8'h40);
      repeat (3) @(negedge clk);
      rd8(3'd4, d);    chk("R7 held tap no re-set", {8'h0, d}, 16'h0);
      rt_tap_i = 1'b0;
      repeat (2) @(negedge clk);
      rt_tap_i = 1'b1;
      @(negedge clk);
      wr(3'd4, 8'h00);
      rd8(3'd4, d);    chk("R9 zero write keeps flag", {8'h0, d}, 16'h40);
      wr(3'd4, 8'h20);
      rd8(3'd4, d);    chk("R9 neighbour clear keeps flag", {8'h0, d}, 16'h40);

      // R11: masking
      chk("R11 no irq with mask clear", {15'h0, irq_o}, 16'h0);
      wr(3'd3, 8'h40);
      chk("R11 irq with matching mask", {15'h0, irq_o}, 16'h1);
      rd8(3'd3, d);    chk("R11 mask readback", {8'h0, d}, 16'h40);
      wr(3'd3, 8'hFF);
      rd8(3'd3, d);    chk("R12 mask unused bits zero", {8'h0, d}, 16'hE0);
      wr(3'd3, 8'h80);
      chk("R11 no irq with other mask", {15'h0, irq_o}, 16'h0);
      wr(3'd3, 8'h40);
      wr(3'd4, 8'h40);
      chk("R11 irq drops on clear", {15'h0, irq_o}, 16'h0);

      // R10: set and clear on the same clock
      rt_tap_i = 1'b0;
      repeat (2) @(negedge clk);
      rt_tap_i = 1'b1;
      wr(3'd4, 8'h40);
      rd8(3'd4, d);    chk("R10 set wins over clear", {8'h0, d}, 16'h40);
      rt_tap_i = 1'b0;
      wr(3'd4, 8'hFF);

      // R8: accumulator rollover
      pa_event_i = 1'b1;
      repeat (255) @(negedge clk);
      pa_event_i = 1'b0;
      rd8(3'd5, d);    chk("R8 accumulator at 0xFF", {8'h0, d}, 16'hFF);
      rd8(3'd4, d);    chk("R8 no flag before wrap", {8'h0, d}, 16'h0);
      pa_event_i = 1'b1;
      @(negedge clk);
      pa_event_i = 1'b0;
      rd8(3'd5, d);    chk("R8 accumulator wraps", {8'h0, d}, 16'h0);
      rd8(3'd4, d);    chk("R8 flag bit 5 set", {8'h0, d}, 16'h20);
      chk("R12 flag low bits zero", {11'h0, d[4:0]}, 16'h0);

      // R6: counter overflow at divide 1
      do_reset();
      guard = 0;
      rd16(c0);
      while (c0 != 16'hFFFF && guard < 70000) begin
         @(negedge clk);
         rd16(c0);
         guard++;
      end
      chk("R6 reached 0xFFFF", c0, 16'hFFFF);
      rd8(3'd4, d);    chk("R6 no flag before wrap", {8'h0, d}, 16'h0);
      @(negedge clk);
      rd16(c1);        chk("R6 count wraps to zero", c1, 16'h0);
      rd8(3'd4, d);    chk("R6 wrap flag bit 7", {8'h0, d}, 16'h80);
      wr(3'd3, 8'h80);
      chk("R11 irq from wrap flag", {15'h0, irq_o}, 16'h1);

      summary();
      $finish;
   end

endmodule